// File: doc/BRIEF.md
# Gaussian-Weighted Window Similarity Scorer with Best-Two Tracker

The block takes one image window per clock, together with a reference kernel of the same size. For every element it forms the absolute difference between the window pixel and the kernel value. It turns that difference into a table index, looks up a Gaussian weight in a 64-entry table and adds the weights of all elements in a registered adder tree. The result is one similarity score per accepted window, at a fixed latency. Each window carries its row and column, and these travel down the pipeline beside the data, so every score leaves with its own position.

A tracker at the end of the pipeline watches the scores of the current frame and keeps the two largest, each with its position. A start-of-frame marker on a window clears both slots. An end-of-frame marker raises a one-cycle done pulse once the last score of the frame has been ranked, and the slots hold their values until the next frame starts. The weight table is loaded word by word through a write port before a frame is streamed. The index shift is an input and is sampled together with each window.

Top module: `gauss_score_top2`

## Requirements
- R1: For each lane the table index is min(|pixel - kernel| >> diff_shift, 63), using the diff_shift value sampled with that window.
- R2: A write with tbl_we high stores tbl_data (16 bits, unsigned) at table address tbl_addr. Windows accepted after that clock edge use the new entry.
- R3: The score of a window is the unsigned sum of the table entries selected by all lanes. It appears with score_valid high exactly 2 + ceil(log2(LANES)) clock edges after the edge that accepts in_valid, and one window per cycle is sustained.
- R4: score_row and score_col equal the in_row and in_col of the window whose score is presented.
- R5: A score strictly greater than the best slot (or any score when the best slot is empty) becomes the best, and the previous best contents, including its valid flag, move into the second slot.
- R6: A score not above the best but strictly greater than the second slot (or any such score when the second slot is empty) replaces the second slot, and the best slot is unchanged.
- R7: A score equal to a filled slot does not displace that slot, and the stored position is kept.
- R8: A window marked in_sof empties both slots, and its own score becomes the best entry with second_valid low, when that score reaches the tracker.
- R9: frame_done is high for one cycle, one edge after the score of the window marked in_eof is presented. In that cycle the slots show the final ranking of the frame.
- R10: After reset, score_valid, best_valid, second_valid and frame_done are low and all scores are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table write address |
| tbl_data | input | 16 | Table write data |
| diff_shift | input | SHIFT_W | Right shift applied to each absolute difference |
| in_valid | input | 1 | Window present this cycle |
| in_sof | input | 1 | Window is the first of a frame |
| in_eof | input | 1 | Window is the last of a frame |
| in_row | input | 12 | Window row |
| in_col | input | 12 | Window column |
| in_pix | input | LANES*PIX_W | Window pixels, lane i at bits [i*PIX_W +: PIX_W] |
| in_kern | input | LANES*PIX_W | Kernel values, same lane layout |
| score_valid | output | 1 | Score present |
| score | output | 16+clog2(LANES) | Window score |
| score_row | output | 12 | Row of the scored window |
| score_col | output | 12 | Column of the scored window |
| best_valid | output | 1 | Best slot filled |
| best_score | output | 16+clog2(LANES) | Highest score of the frame |
| best_row | output | 12 | Row of the highest score |
| best_col | output | 12 | Column of the highest score |
| second_valid | output | 1 | Second slot filled |
| second_score | output | 16+clog2(LANES) | Second highest score |
| second_row | output | 12 | Row of the second score |
| second_col | output | 12 | Column of the second score |
| frame_done | output | 1 | One-cycle pulse once the frame ranking is final |

## Verification
The tracker can clear its slots for a new frame in the same cycle that it must insert a score. The two actions also meet when an end-of-frame window is followed with no gap by a start-of-frame window, so that the done pulse of one frame and the clear of the next fall on adjacent edges. The bench provokes both by streaming frames back to back and by sending a frame of a single window that carries both markers. For each frame it compares the slot contents seen in the done cycle against a ranking model kept in the bench, and it also checks every score and its position in the cycle the latency rule predicts.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
   localparam int COORD_W = 12;
   localparam int TBL_AW  = 6;
   localparam int TBL_W   = 16;

   typedef struct packed {
      logic               vld;
      logic               sof;
      logic               eof;
      logic [COORD_W-1:0] row;
      logic [COORD_W-1:0] col;
   } gsc_meta_t;
endpackage

// File: rtl/gsc_lane.sv
module gsc_lane #(
   parameter int PIX_W   = 16,
   parameter int SHIFT_W = 4,
   parameter int AW      = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PIX_W-1:0]   pix,
   input  logic [PIX_W-1:0]   kern,
   input  logic [SHIFT_W-1:0] shift,
   output logic [AW-1:0]      idx_q
);
   logic [PIX_W-1:0] diff;
   logic [PIX_W-1:0] shd;
   logic [AW-1:0]    idx_d;

   always_comb begin
      diff = (pix >= kern) ? (pix - kern) : (kern - pix);
      shd  = diff >> shift;
   end

   generate
      if (PIX_W > AW) begin : g_sat
         always_comb idx_d = (|shd[PIX_W-1:AW]) ? {AW{1'b1}} : shd[AW-1:0];

         // R1: a shifted difference at or above the table end lands on the last entry
         p_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (|shd[PIX_W-1:AW]) |=> (idx_q == {AW{1'b1}}));
      end else begin : g_nosat
         always_comb idx_d = AW'(shd);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= idx_d;
   end
endmodule

// File: rtl/gsc_lut.sv
module gsc_lut #(
   parameter int LANES = 4,
   parameter int AW    = 6,
   parameter int DW    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [DW-1:0]       wdata,
   input  logic [LANES*AW-1:0] idx_flat,
   output logic [LANES*DW-1:0] rd_flat
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_flat <= '0;
      else begin
         for (int l = 0; l < LANES; l++)
            rd_flat[l*DW +: DW] <= mem[idx_flat[l*AW +: AW]];
      end
   end

   // R2: a read of a just-written address returns the written word
   p_wr_then_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we) && (idx_flat[AW-1:0] == $past(waddr))) |=> (rd_flat[DW-1:0] == $past(wdata, 2)));
endmodule

// File: rtl/gsc_tree.sv
module gsc_tree #(
   parameter int LANES = 4,
   parameter int IN_W  = 16,
   parameter int OUT_W = 18
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LANES*IN_W-1:0] in_flat,
   output logic [OUT_W-1:0]      sum
);
   localparam int LVLS = $clog2(LANES);
   localparam int NPAD = 1 << LVLS;
   localparam int HALF = NPAD / 2;

   logic [OUT_W-1:0] leaf [NPAD];
   logic [OUT_W-1:0] stg  [LVLS][HALF];

   always_comb begin
      for (int n = 0; n < NPAD; n++)
         leaf[n] = (n < LANES) ? OUT_W'(in_flat[n*IN_W +: IN_W]) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LVLS; l++)
            for (int n = 0; n < HALF; n++)
               stg[l][n] <= '0;
      end else begin
         for (int l = 0; l < LVLS; l++)
            for (int n = 0; n < HALF; n++)
               if (n < (NPAD >> (l + 1)))
                  stg[l][n] <= (l == 0) ? (leaf[2*n] + leaf[2*n+1])
                             : (stg[(l == 0) ? 0 : l-1][2*n] + stg[(l == 0) ? 0 : l-1][2*n+1]);
      end
   end

   assign sum = stg[LVLS-1][0];
endmodule

// File: rtl/gsc_top2.sv
module gsc_top2 #(
   parameter int SW = 18,
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic          in_sof,
   input  logic          in_eof,
   input  logic [SW-1:0] in_score,
   input  logic [CW-1:0] in_row,
   input  logic [CW-1:0] in_col,
   output logic          b_vld,
   output logic [SW-1:0] b_score,
   output logic [CW-1:0] b_row,
   output logic [CW-1:0] b_col,
   output logic          s_vld,
   output logic [SW-1:0] s_score,
   output logic [CW-1:0] s_row,
   output logic [CW-1:0] s_col,
   output logic          done
);
   logic beats_best, beats_second;

   always_comb begin
      beats_best   = !b_vld || (in_score > b_score);
      beats_second = !s_vld || (in_score > s_score);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_vld <= 1'b0; b_score <= '0; b_row <= '0; b_col <= '0;
         s_vld <= 1'b0; s_score <= '0; s_row <= '0; s_col <= '0;
         done  <= 1'b0;
      end else begin
         done <= in_vld && in_eof;
         if (in_vld) begin
            if (in_sof) begin
               b_vld <= 1'b1; b_score <= in_score; b_row <= in_row; b_col <= in_col;
               s_vld <= 1'b0; s_score <= '0;       s_row <= '0;     s_col <= '0;
            end else if (beats_best) begin
               s_vld <= b_vld; s_score <= b_score; s_row <= b_row; s_col <= b_col;
               b_vld <= 1'b1;  b_score <= in_score; b_row <= in_row; b_col <= in_col;
            end else if (beats_second) begin
               s_vld <= 1'b1;  s_score <= in_score; s_row <= in_row; s_col <= in_col;
            end
         end
      end
   end

   // R5: whenever both slots are filled the best is not below the second
   p_rank_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (b_vld && s_vld) |-> (b_score >= s_score));

   // R7: an arrival not above the filled best leaves the best slot untouched
   p_tie_keeps_best_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_sof && b_vld && (in_score <= b_score)) |=>
         ($stable(b_score) && $stable(b_row) && $stable(b_col)));

   // R8: a start-of-frame arrival leaves exactly one filled slot holding that score
   p_sof_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_sof) |=> (b_vld && !s_vld && (b_score == $past(in_score))));

   // R9: the done pulse only follows an end-of-frame arrival
   p_done_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(in_vld && in_eof));
endmodule

// File: rtl/gauss_score_top2.sv
module gauss_score_top2 #(
   parameter int LANES   = 4,
   parameter int PIX_W   = 16,
   parameter int SHIFT_W = 4,
   localparam int CW     = gsc_pkg::COORD_W,
   localparam int AW     = gsc_pkg::TBL_AW,
   localparam int TW     = gsc_pkg::TBL_W,
   localparam int SCW    = TW + $clog2(LANES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tbl_we,
   input  logic [AW-1:0]          tbl_addr,
   input  logic [TW-1:0]          tbl_data,
   input  logic [SHIFT_W-1:0]     diff_shift,
   input  logic                   in_valid,
   input  logic                   in_sof,
   input  logic                   in_eof,
   input  logic [CW-1:0]          in_row,
   input  logic [CW-1:0]          in_col,
   input  logic [LANES*PIX_W-1:0] in_pix,
   input  logic [LANES*PIX_W-1:0] in_kern,
   output logic                   score_valid,
   output logic [SCW-1:0]         score,
   output logic [CW-1:0]          score_row,
   output logic [CW-1:0]          score_col,
   output logic                   best_valid,
   output logic [SCW-1:0]         best_score,
   output logic [CW-1:0]          best_row,
   output logic [CW-1:0]          best_col,
   output logic                   second_valid,
   output logic [SCW-1:0]         second_score,
   output logic [CW-1:0]          second_row,
   output logic [CW-1:0]          second_col,
   output logic                   frame_done
);
   import gsc_pkg::*;

   localparam int LVLS = $clog2(LANES);
   localparam int LAT  = 2 + LVLS;

   generate
      if (LANES < 2)   begin : g_bad_lanes $error("LANES must be at least 2"); end
      if (PIX_W < 2)   begin : g_bad_pix   $error("PIX_W must be at least 2"); end
      if (SHIFT_W < 1) begin : g_bad_shift $error("SHIFT_W must be at least 1"); end
   endgenerate

   logic [LANES*AW-1:0] idx_flat;
   logic [LANES*TW-1:0] wgt_flat;
   logic [SCW-1:0]      tree_sum;
   gsc_meta_t           meta_q [LAT];
   gsc_meta_t           meta_in;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         gsc_lane #(.PIX_W(PIX_W), .SHIFT_W(SHIFT_W), .AW(AW)) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .pix   (in_pix[g*PIX_W +: PIX_W]),
            .kern  (in_kern[g*PIX_W +: PIX_W]),
            .shift (diff_shift),
            .idx_q (idx_flat[g*AW +: AW])
         );
      end
   endgenerate

   gsc_lut #(.LANES(LANES), .AW(AW), .DW(TW)) lut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (tbl_we),
      .waddr    (tbl_addr),
      .wdata    (tbl_data),
      .idx_flat (idx_flat),
      .rd_flat  (wgt_flat)
   );

   gsc_tree #(.LANES(LANES), .IN_W(TW), .OUT_W(SCW)) tree_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_flat (wgt_flat),
      .sum     (tree_sum)
   );

   always_comb begin
      meta_in.vld = in_valid;
      meta_in.sof = in_valid & in_sof;
      meta_in.eof = in_valid & in_eof;
      meta_in.row = in_row;
      meta_in.col = in_col;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < LAT; k++) meta_q[k] <= '0;
      end else begin
         meta_q[0] <= meta_in;
         for (int k = 1; k < LAT; k++) meta_q[k] <= meta_q[k-1];
      end
   end

   assign score_valid = meta_q[LAT-1].vld;
   assign score       = tree_sum;
   assign score_row   = meta_q[LAT-1].row;
   assign score_col   = meta_q[LAT-1].col;

   gsc_top2 #(.SW(SCW), .CW(CW)) trk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (meta_q[LAT-1].vld),
      .in_sof   (meta_q[LAT-1].sof),
      .in_eof   (meta_q[LAT-1].eof),
      .in_score (tree_sum),
      .in_row   (meta_q[LAT-1].row),
      .in_col   (meta_q[LAT-1].col),
      .b_vld    (best_valid),
      .b_score  (best_score),
      .b_row    (best_row),
      .b_col    (best_col),
      .s_vld    (second_valid),
      .s_score  (second_score),
      .s_row    (second_row),
      .s_col    (second_col),
      .done     (frame_done)
   );

   // R4: a score leaves with the position that entered LAT edges earlier (checked one stage back)
   p_coord_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      meta_q[1].vld |-> ($past(in_valid, 2) && (meta_q[1].row == $past(in_row, 2))));
endmodule

// File: tb/gauss_score_top2_tb_top.sv
module gauss_score_top2_tb_top;
   localparam int LANES   = 4;
   localparam int PIX_W   = 8;
   localparam int SHIFT_W = 4;
   localparam int SCW     = 16 + $clog2(LANES);
   localparam int LAT     = 2 + $clog2(LANES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_we = 1'b0;
   logic [5:0] tbl_addr = '0;
   logic [15:0] tbl_data = '0;
   logic [SHIFT_W-1:0] diff_shift = '0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [11:0] in_row = '0, in_col = '0;
   logic [LANES*PIX_W-1:0] in_pix = '0, in_kern = '0;
   logic score_valid, best_valid, second_valid, frame_done;
   logic [SCW-1:0] score, best_score, second_score;
   logic [11:0] score_row, score_col, best_row, best_col, second_row, second_col;

   always #2 clk = ~clk;

   gauss_score_top2 #(.LANES(LANES), .PIX_W(PIX_W), .SHIFT_W(SHIFT_W)) dut_i (.*);

   int n_chk = 0, n_fail = 0, cyc = 0;
   int unsigned tbl_m [64];
   int unsigned seed = 32'h1234_5678;

   int unsigned q_sc[$]; int q_r[$], q_c[$], q_at[$];
   int fq_bv[$], fq_bs[$], fq_br[$], fq_bc[$], fq_sv[$], fq_ss[$], fq_sr[$], fq_sc[$], fq_at[$];
   int m_bv, m_bs, m_br, m_bc, m_sv, m_ss, m_sr, m_sc;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 8;
   endfunction

   function automatic int idx_of(int p, int k, int s);
      int d;
      d = (p > k) ? p - k : k - p;
      d = d >> s;
      return (d > 63) ? 63 : d;
   endfunction

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic load(input int a, input int v);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 6'(a); tbl_data = 16'(v);
      tbl_m[a] = v;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic send(input bit sof, input bit eof, input int row, input int col,
                       input int s, input logic [LANES*PIX_W-1:0] p, input logic [LANES*PIX_W-1:0] k);
      int sc;
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof; in_eof = eof;
      in_row = 12'(row); in_col = 12'(col); diff_shift = SHIFT_W'(s);
      in_pix = p; in_kern = k;
      sc = 0;
      for (int l = 0; l < LANES; l++)
         sc += tbl_m[idx_of(int'(p[l*PIX_W +: PIX_W]), int'(k[l*PIX_W +: PIX_W]), s)];
      q_sc.push_back(sc); q_r.push_back(row); q_c.push_back(col); q_at.push_back(cyc + LAT);
      if (sof) begin
         m_bv = 1; m_bs = sc; m_br = row; m_bc = col; m_sv = 0; m_ss = 0; m_sr = 0; m_sc = 0;
      end else if (!m_bv || sc > m_bs) begin
         m_sv = m_bv; m_ss = m_bs; m_sr = m_br; m_sc = m_bc;
         m_bv = 1; m_bs = sc; m_br = row; m_bc = col;
      end else if (!m_sv || sc > m_ss) begin
         m_sv = 1; m_ss = sc; m_sr = row; m_sc = col;
      end
      if (eof) begin
         fq_bv.push_back(m_bv); fq_bs.push_back(m_bs); fq_br.push_back(m_br); fq_bc.push_back(m_bc);
         fq_sv.push_back(m_sv); fq_ss.push_back(m_ss); fq_sr.push_back(m_sr); fq_sc.push_back(m_sc);
         fq_at.push_back(cyc + LAT + 1);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
   endtask

   function automatic logic [LANES*PIX_W-1:0] fill(input int v);
      logic [LANES*PIX_W-1:0] r;
      for (int l = 0; l < LANES; l++) r[l*PIX_W +: PIX_W] = PIX_W'(v);
      return r;
   endfunction

   // uniform diff d on every lane, with the sign of the difference varying by lane
   task automatic send_d(input bit sof, input bit eof, input int row, input int col, input int d);
      logic [LANES*PIX_W-1:0] p, k;
      for (int l = 0; l < LANES; l++) begin
         p[l*PIX_W +: PIX_W] = PIX_W'((l % 2) ? 0 : d);
         k[l*PIX_W +: PIX_W] = PIX_W'((l % 2) ? d : 0);
      end
      send(sof, eof, row, col, 0, p, k);
   endtask

   // output monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (score_valid) begin
            if (q_sc.size() == 0) chk(1'b0, "R3 unexpected score_valid", 1, 0);
            else begin
               chk(score == SCW'(q_sc[0]), "R1 R2 R3 score", int'(score), int'(q_sc[0]));
               chk(cyc == q_at[0], "R3 latency cycle", cyc, q_at[0]);
               chk(score_row == 12'(q_r[0]) && score_col == 12'(q_c[0]), "R4 position row*4096+col",
                   int'(score_row) * 4096 + int'(score_col), q_r[0] * 4096 + q_c[0]);
               void'(q_sc.pop_front()); void'(q_r.pop_front()); void'(q_c.pop_front()); void'(q_at.pop_front());
            end
         end
         if (frame_done) begin
            if (fq_at.size() == 0) chk(1'b0, "R9 unexpected frame_done", 1, 0);
            else begin
               chk(cyc == fq_at[0], "R9 done cycle", cyc, fq_at[0]);
               chk(best_valid == fq_bv[0][0] && best_score == SCW'(fq_bs[0]), "R5 R8 best score",
                   int'(best_score), fq_bs[0]);
               chk(best_row == 12'(fq_br[0]) && best_col == 12'(fq_bc[0]), "R5 R7 best position",
                   int'(best_row) * 4096 + int'(best_col), fq_br[0] * 4096 + fq_bc[0]);
               chk(second_valid == fq_sv[0][0], "R8 second valid", int'(second_valid), fq_sv[0]);
               chk(!fq_sv[0] || (second_score == SCW'(fq_ss[0]) && second_row == 12'(fq_sr[0])
                   && second_col == 12'(fq_sc[0])), "R6 R7 second score",
                   int'(second_score), fq_ss[0]);
               void'(fq_bv.pop_front()); void'(fq_bs.pop_front()); void'(fq_br.pop_front());
               void'(fq_bc.pop_front()); void'(fq_sv.pop_front()); void'(fq_ss.pop_front());
               void'(fq_sr.pop_front()); void'(fq_sc.pop_front()); void'(fq_at.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!score_valid && !best_valid && !second_valid && !frame_done, "R10 flags after reset",
          int'({score_valid, best_valid, second_valid, frame_done}), 0);
      chk(best_score == '0 && second_score == '0, "R10 scores after reset", int'(best_score), 0);

      // R2: load a monotonically falling bell-like table
      for (int a = 0; a < 64; a++) load(a, (64 - a) * (64 - a) * 15);

      // R1: sweep every difference for several shifts; one frame per shift
      for (int s = 0; s < 9; s += 2)
         for (int d = 0; d < 256; d++) begin
            logic [LANES*PIX_W-1:0] p, k;
            p[7:0] = 8'(d);          k[7:0] = 8'd0;
            p[15:8] = 8'd0;          k[15:8] = 8'(d);
            p[23:16] = 8'd255;       k[23:16] = 8'(255 - d);
            p[31:24] = 8'(d * 7);    k[31:24] = 8'(d * 13);
            send(d == 0, d == 255, s, d, s, p, k);
         end
      idle(3);

      // random frames with gaps, then back to back (eof then sof the next cycle)
      for (int f = 0; f < 6; f++) begin
         for (int w = 0; w < 40; w++) begin
            send(w == 0, w == 39, f, w, (f < 2) ? 0 : int'(rnd() % 8),
                 LANES*PIX_W'(rnd()), LANES*PIX_W'(rnd()));
            if (f % 2 == 0 && rnd() % 4 == 0) idle(int'(rnd() % 3) + 1);
         end
      end

      // R7 R5 R6: directed ties and reorderings
      send_d(1, 0, 1, 1, 10);
      send_d(0, 0, 1, 2, 10);
      send_d(0, 0, 1, 3, 10);
      send_d(0, 0, 1, 4, 5);
      send_d(0, 0, 1, 5, 7);
      send_d(0, 0, 1, 6, 20);
      send_d(0, 0, 1, 7, 7);
      send_d(0, 1, 1, 8, 6);
      // R8: a single window carrying both markers right after the previous frame
      send_d(1, 1, 2, 9, 30);
      idle(2);
      // frame without a start marker keeps ranking on top of the previous frame
      send_d(0, 1, 3, 3, 40);
      idle(3);

      // R2: rewrite one entry and use it
      load(0, 16'h1234);
      idle(1);
      send(1, 0, 4, 0, 0, fill(50), fill(50));
      send(0, 0, 4, 1, 3, fill(7), fill(9));
      send(0, 1, 4, 2, 0, fill(0), fill(0));

      idle(LAT + 4);
      chk(q_sc.size() == 0, "R3 scores still pending", q_sc.size(), 0);
      chk(fq_at.size() == 0, "R9 frames still pending", fq_at.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule